// File: doc/BRIEF.md
# Clock-Controller Register Bank with Atomic Bit Aliases

This block is the word-addressed register store of a clock and power controller. It answers a simple single-cycle request bus: one request per cycle, with a response one cycle later. The decode range is split into two windows. The low window holds plain control words that are overwritten on a write. The upper window holds aliased registers. Each aliased register owns four consecutive words: a direct word, a bit-set word, a bit-clear word and a bit-toggle word. Any of the four reads back the same stored value. Software can therefore change single fields of shared PLL and divider words without a read-modify-write race on the bus. A few plain words follow the aliased groups in the upper window.

Reset values are parameters. The aliased registers that represent PLL controls also get a lock indication bit forced high at reset, so downstream logic sees every PLL as locked. Every access that is malformed or unmapped is refused with an error flag and changes nothing.

Top module: `regbank_top`

## Requirements
- R1: The word index is the byte address shifted right by two. Only word-sized accesses (`req_size` = 2; 0 is byte, 1 is halfword) with `req_addr[1:0]` = 0 are accepted. Any other access returns `rsp_err` = 1 and changes no register.
- R2: Plain window: the byte addresses from 0 up to 4*NUM_PLAIN are plain registers. A write replaces the whole word, and a read returns it.
- R3: Aliased window: starting at byte 0x4000, group k occupies bytes 0x4000+16k to 0x400F+16k. A write to the word at offset 0 of the group replaces the register.
- R4: A write to offset 4 of a group ORs the write data into the register.
- R5: A write to offset 8 of a group clears the register bits that are 1 in the write data.
- R6: A write to offset 12 of a group XORs the write data into the register.
- R7: A read of any of the four words of a group returns the register value. The NUM_APL plain words that follow the groups (starting at 0x4000+16*NUM_ALIAS) are overwritten by writes and have no alias behaviour.
- R8: An address at or above 0x5000, or one that lies in neither window, returns `rsp_err` = 1 with `rsp_rdata` = 0 and changes no register.
- R9: After reset, each register holds its parameter value. With the defaults these are: plain {0xFFFFFFFF, 0x00000079, 0x00A50000, 0x00000000}; groups {0x80002002, 0x80001001, 0x80010040, 0x00000011}; upper plain words {0x00001073, 0x00005071}. Bit 31 (the lock bit) is forced to 1 in every group whose bit is set in PLL_MASK (default 4'b0111).
- R10: The response comes one cycle after the request. `rsp_rdata` carries the addressed register value from before that request's write, so a write returns the old value and a read in the very next cycle sees the new one.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | AW (16) | Byte address |
| req_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request refused (malformed or unmapped) |
| rsp_rdata | output | DW (32) | Pre-access value of the addressed register, 0 on error |

## Verification
The assertions watch the response timing on every cycle, the zero data on refused accesses, and the frozen register state on refusals, reads and idle cycles. They also check the forced lock bits in the first cycle after reset. The set, clear and toggle arithmetic, the window and group decode, the aliased read-back and the reset values are shown only by the bench's vectors. Those vectors compare each read against a value tracked by hand through the sequence of writes.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int unsigned IDX_W = 12;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLR   = 2'd2,
      OP_TOG   = 2'd3
   } alias_op_e;

   typedef enum logic [1:0] {
      WIN_NONE   = 2'd0,
      WIN_PLAIN  = 2'd1,
      WIN_ALIAS  = 2'd2,
      WIN_APLAIN = 2'd3
   } win_e;

   typedef struct packed {
      win_e             win;
      alias_op_e        op;
      logic [IDX_W-1:0] idx;
   } dec_t;

endpackage

// File: rtl/rb_decode.sv
module rb_decode
   import regbank_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned NUM_PLAIN   = 4,
   parameter int unsigned NUM_ALIAS   = 4,
   parameter int unsigned NUM_APL     = 2,
   parameter logic [31:0] ALIAS_BASE  = 32'h0000_4000,
   parameter logic [31:0] RANGE_BYTES = 32'h0000_5000
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   output dec_t          dec
);
   localparam logic [31:0] PLAIN_END  = 32'(NUM_PLAIN * 4);
   localparam logic [31:0] ALIAS_SPAN = 32'(NUM_ALIAS * 16);
   localparam logic [31:0] APL_END    = 32'(NUM_ALIAS * 16 + NUM_APL * 4);

   logic [31:0] a32;
   logic [31:0] off;
   logic [31:0] aoff;
   logic        shape_ok;

   always_comb begin
      a32      = 32'(addr);
      off      = a32 - ALIAS_BASE;
      aoff     = off - ALIAS_SPAN;
      shape_ok = (size == SZ_WORD) && (a32[1:0] == 2'b00);
      dec      = '{win: WIN_NONE, op: OP_WRITE, idx: '0};
      if (shape_ok && (a32 < RANGE_BYTES)) begin
         if (a32 < PLAIN_END) begin
            dec.win = WIN_PLAIN;
            dec.idx = IDX_W'(a32 >> 2);
         end else if ((a32 >= ALIAS_BASE) && (off < ALIAS_SPAN)) begin
            dec.win = WIN_ALIAS;
            dec.idx = IDX_W'(off >> 4);
            dec.op  = alias_op_e'(off[3:2]);
         end else if ((a32 >= ALIAS_BASE) && (off < APL_END)) begin
            dec.win = WIN_APLAIN;
            dec.idx = IDX_W'(aoff >> 2);
         end
      end
   end
endmodule

// File: rtl/rb_plain_reg.sv
module rb_plain_reg #(
   parameter int unsigned   DW  = 32,
   parameter logic [DW-1:0] RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/rb_alias_reg.sv
module rb_alias_reg
   import regbank_pkg::*;
#(
   parameter int unsigned   DW  = 32,
   parameter logic [DW-1:0] RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  alias_op_e     op,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   logic [DW-1:0] nxt;

   always_comb begin
      unique case (op)
         OP_SET:  nxt = q | wdata;
         OP_CLR:  nxt = q & ~wdata;
         OP_TOG:  nxt = q ^ wdata;
         default: nxt = wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= nxt;
   end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
   import regbank_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 32,
   parameter int unsigned NUM_PLAIN   = 4,
   parameter int unsigned NUM_ALIAS   = 4,
   parameter int unsigned NUM_APL     = 2,
   parameter logic [31:0] ALIAS_BASE  = 32'h0000_4000,
   parameter logic [31:0] RANGE_BYTES = 32'h0000_5000,
   parameter int unsigned LOCK_BIT    = 31,
   parameter logic [NUM_ALIAS-1:0] PLL_MASK = 4'b0111,
   parameter logic [NUM_PLAIN-1:0][DW-1:0] PLAIN_RST =
      {32'h0000_0000, 32'h00A5_0000, 32'h0000_0079, 32'hFFFF_FFFF},
   parameter logic [NUM_ALIAS-1:0][DW-1:0] ALIAS_RST =
      {32'h0000_0011, 32'h0001_0040, 32'h0000_1001, 32'h0000_2002},
   parameter logic [NUM_APL-1:0][DW-1:0] APL_RST =
      {32'h0000_5071, 32'h0000_1073}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [1:0]    req_size,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [DW-1:0] rsp_rdata
);
   localparam int unsigned NUM_REGS = NUM_PLAIN + NUM_ALIAS + NUM_APL;
   localparam int unsigned STATE_W  = NUM_REGS * DW;

   // elaboration-time parameter checks
   if (AW < 15 || AW > 32) begin : g_bad_aw
      $error("regbank_top: AW must lie in 15..32");
   end
   if (NUM_PLAIN < 1 || NUM_ALIAS < 1 || NUM_APL < 1) begin : g_bad_count
      $error("regbank_top: every register count must be at least one");
   end
   if (NUM_PLAIN * 4 > ALIAS_BASE) begin : g_bad_plain
      $error("regbank_top: plain window overlaps the aliased window");
   end
   if (ALIAS_BASE + NUM_ALIAS * 16 + NUM_APL * 4 > RANGE_BYTES) begin : g_bad_alias
      $error("regbank_top: aliased window exceeds the decode range");
   end
   if (LOCK_BIT >= DW) begin : g_bad_lock
      $error("regbank_top: lock bit outside the data word");
   end
   if (NUM_PLAIN > (1 << IDX_W) || NUM_ALIAS > (1 << IDX_W)) begin : g_bad_idx
      $error("regbank_top: register count exceeds index width");
   end

   dec_t dec;
   logic acc_ok;
   logic wr_go;

   logic [NUM_PLAIN-1:0][DW-1:0] plain_q;
   logic [NUM_ALIAS-1:0][DW-1:0] alias_q;
   logic [NUM_APL-1:0][DW-1:0]   apl_q;
   logic [STATE_W-1:0]           state_flat;
   logic [DW-1:0]                rd_val;

   rb_decode #(
      .AW(AW), .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS), .NUM_APL(NUM_APL),
      .ALIAS_BASE(ALIAS_BASE), .RANGE_BYTES(RANGE_BYTES)
   ) u_dec (
      .addr(req_addr),
      .size(req_size),
      .dec (dec)
   );

   assign acc_ok = req_valid && (dec.win != WIN_NONE);
   assign wr_go  = acc_ok && req_write;

   // low window: overwrite-only words
   for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
      rb_plain_reg #(.DW(DW), .RST(PLAIN_RST[i])) u_reg (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (wr_go && dec.win == WIN_PLAIN && dec.idx == IDX_W'(i)),
         .wdata(req_wdata),
         .q    (plain_q[i])
      );
   end

   // upper window: four-word groups; PLL groups start with the lock bit high
   for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
      logic we_k;
      assign we_k = wr_go && dec.win == WIN_ALIAS && dec.idx == IDX_W'(k);
      if (PLL_MASK[k]) begin : g_pll
         localparam logic [DW-1:0] RST_K = ALIAS_RST[k] | (DW'(1) << LOCK_BIT);
         rb_alias_reg #(.DW(DW), .RST(RST_K)) u_reg (
            .clk(clk), .rst_n(rst_n), .we(we_k), .op(dec.op),
            .wdata(req_wdata), .q(alias_q[k])
         );
      end else begin : g_other
         rb_alias_reg #(.DW(DW), .RST(ALIAS_RST[k])) u_reg (
            .clk(clk), .rst_n(rst_n), .we(we_k), .op(dec.op),
            .wdata(req_wdata), .q(alias_q[k])
         );
      end
   end

   // upper window: plain words after the groups
   for (genvar j = 0; j < NUM_APL; j++) begin : g_apl
      rb_plain_reg #(.DW(DW), .RST(APL_RST[j])) u_reg (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (wr_go && dec.win == WIN_APLAIN && dec.idx == IDX_W'(j)),
         .wdata(req_wdata),
         .q    (apl_q[j])
      );
   end

   assign state_flat = {apl_q, alias_q, plain_q};

   // read selection (pre-write value; the op field does not matter)
   always_comb begin
      rd_val = '0;
      unique case (dec.win)
         WIN_PLAIN: begin
            for (int i = 0; i < NUM_PLAIN; i++)
               if (dec.idx == IDX_W'(i)) rd_val = plain_q[i];
         end
         WIN_ALIAS: begin
            for (int k = 0; k < NUM_ALIAS; k++)
               if (dec.idx == IDX_W'(k)) rd_val = alias_q[k];
         end
         WIN_APLAIN: begin
            for (int j = 0; j < NUM_APL; j++)
               if (dec.idx == IDX_W'(j)) rd_val = apl_q[j];
         end
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && (dec.win == WIN_NONE);
         rsp_rdata <= acc_ok ? rd_val : '0;
      end
   end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
   parameter int unsigned DW        = 32,
   parameter int unsigned NUM_ALIAS = 4,
   parameter int unsigned STATE_W   = 320,
   parameter int unsigned LOCK_BIT  = 31,
   parameter logic [NUM_ALIAS-1:0] PLL_MASK = '0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_write,
   input logic                    rsp_valid,
   input logic                    rsp_err,
   input logic [DW-1:0]           rsp_rdata,
   input logic [STATE_W-1:0]      state_flat,
   input logic [NUM_ALIAS*DW-1:0] alias_flat
);
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0));

   p_err_no_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> $stable(state_flat));

   p_read_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(req_write)) |-> $stable(state_flat));

   p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(state_flat));

   for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_lock
      if (PLL_MASK[k]) begin : g_on
         p_lock_at_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
            first_q |-> alias_flat[k*DW + LOCK_BIT]);
      end
   end
endmodule

bind regbank_top regbank_chk #(
   .DW(DW), .NUM_ALIAS(NUM_ALIAS), .STATE_W(STATE_W),
   .LOCK_BIT(LOCK_BIT), .PLL_MASK(PLL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .state_flat(state_flat),
   .alias_flat(alias_q)
);

// File: tb/sim_regbank_top.sv
module sim_regbank_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   regbank_top u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   // {req tag(4), write, size(2), addr(16), wdata(32), exp err, exp rdata(32)}
   localparam int NV = 23;
   localparam logic [87:0] VEC [NV] = '{
      {4'd9, 1'b0, 2'd2, 16'h0000, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R9 plain reset
      {4'd2, 1'b1, 2'd2, 16'h0004, 32'h1234_5678, 1'b0, 32'h0000_0079}, // R2 write, old back
      {4'd2, 1'b0, 2'd2, 16'h0004, 32'h0,         1'b0, 32'h1234_5678}, // R2
      {4'd9, 1'b0, 2'd2, 16'h4000, 32'h0,         1'b0, 32'h8000_2002}, // R9 lock forced
      {4'd4, 1'b1, 2'd2, 16'h4004, 32'h0000_0F00, 1'b0, 32'h8000_2002}, // R4 set
      {4'd7, 1'b0, 2'd2, 16'h4008, 32'h0,         1'b0, 32'h8000_2F02}, // R7 alias read
      {4'd5, 1'b1, 2'd2, 16'h4008, 32'h8000_0002, 1'b0, 32'h8000_2F02}, // R5 clear
      {4'd6, 1'b1, 2'd2, 16'h400C, 32'h0000_FFFF, 1'b0, 32'h0000_2F00}, // R6 toggle
      {4'd6, 1'b0, 2'd2, 16'h400C, 32'h0,         1'b0, 32'h0000_D0FF}, // R6
      {4'd3, 1'b1, 2'd2, 16'h4010, 32'hCAFE_0000, 1'b0, 32'h8000_1001}, // R3 direct
      {4'd3, 1'b0, 2'd2, 16'h4014, 32'h0,         1'b0, 32'hCAFE_0000}, // R3
      {4'd7, 1'b0, 2'd2, 16'h403C, 32'h0,         1'b0, 32'h0000_0011}, // R7 group 3
      {4'd7, 1'b1, 2'd2, 16'h4040, 32'hDEAD_BEEF, 1'b0, 32'h0000_1073}, // R7 upper plain
      {4'd7, 1'b0, 2'd2, 16'h4044, 32'h0,         1'b0, 32'h0000_5071}, // R7 neighbour
      {4'd7, 1'b0, 2'd2, 16'h4040, 32'h0,         1'b0, 32'hDEAD_BEEF}, // R7
      {4'd8, 1'b1, 2'd2, 16'h0010, 32'h0000_FFFF, 1'b1, 32'h0},         // R8 past plain
      {4'd1, 1'b1, 2'd2, 16'h4002, 32'hFFFF_FFFF, 1'b1, 32'h0},         // R1 unaligned
      {4'd1, 1'b1, 2'd1, 16'h4004, 32'hFFFF_FFFF, 1'b1, 32'h0},         // R1 halfword
      {4'd8, 1'b1, 2'd2, 16'h4048, 32'hFFFF_FFFF, 1'b1, 32'h0},         // R8 past upper
      {4'd8, 1'b0, 2'd2, 16'h5000, 32'h0,         1'b1, 32'h0},         // R8 range end
      {4'd1, 1'b0, 2'd2, 16'h4000, 32'h0,         1'b0, 32'h0000_D0FF}, // R1 unchanged
      {4'd1, 1'b0, 2'd2, 16'h0004, 32'h0,         1'b0, 32'h1234_5678}, // R1 unchanged
      {4'd8, 1'b0, 2'd2, 16'h2000, 32'h0,         1'b1, 32'h0}          // R8 gap
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [1:0] sz,
                        input logic [15:0] a, input logic [31:0] d);
      req_valid = 1'b1;
      req_write = wr;
      req_size  = sz;
      req_addr  = a;
      req_wdata = d;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic one(input string tag, input logic wr, input logic [15:0] a,
                      input logic [31:0] d, input logic [31:0] exp);
      drive(wr, 2'd2, a, d);
      @(negedge clk);
      chk(tag, rsp_rdata, exp);
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 valid after reset", 32'(rsp_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [87:0] v;
         string t;
         v = VEC[i];
         drive(v[83], v[82:81], v[80:65], v[64:33]);
         @(negedge clk);
         t = $sformatf("R%0d vec%0d", v[87:84], i);
         chk({t, " valid"}, 32'(rsp_valid), 32'd1);
         chk({t, " err"},   32'(rsp_err),   32'(v[32]));
         chk({t, " data"},  rsp_rdata,      v[31:0]);
         idle();
      end

      // R10: write then read back to back
      drive(1'b1, 2'd2, 16'h000C, 32'hAAAA_5555);
      @(negedge clk);
      chk("R10 write returns old", rsp_rdata, 32'h0);
      drive(1'b0, 2'd2, 16'h000C, 32'h0);
      @(negedge clk);
      chk("R10 next read sees new", rsp_rdata, 32'hAAAA_5555);
      idle();
      @(negedge clk);
      chk("R11 idle no response", 32'(rsp_valid), 32'd0);

      // R5 clear the lock bit of group 1, then R9 reset restores it
      one("R5 clear lock", 1'b1, 16'h4018, 32'h8000_0000, 32'hCAFE_0000);
      one("R5 lock cleared", 1'b0, 16'h4010, 32'h0, 32'h4AFE_0000);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      one("R9 group1 reset", 1'b0, 16'h4010, 32'h0, 32'h8000_1001);
      one("R9 group2 reset", 1'b0, 16'h4020, 32'h0, 32'h8001_0040);
      one("R9 group3 no lock", 1'b0, 16'h4030, 32'h0, 32'h0000_0011);
      one("R9 plain2 reset", 1'b0, 16'h0008, 32'h0, 32'h00A5_0000);
      one("R9 upper plain reset", 1'b0, 16'h4040, 32'h0, 32'h0000_1073);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule